// File: doc/BRIEF.md
# Bus Write Completion Monitor

This block sits beside a pipelined on-chip bus and watches its write data phases one at a time. A phase stays open while the slave holds its ready strobe low to insert wait states. The phase closes in the cycle where ready is high. For every closed phase the monitor produces one pass/fail result. The flag is 1 only when the slave answered with the normal-completion code and the master did not abort at any point in the phase.

Master abort, slave error, slave retry and unknown acknowledge codes all give the same 0 result. Nothing records which of them happened. A bus timeout needs no input of its own, because the slave is required to close the timed-out phase with the error code in the next cycle. When the master aborts inside a burst, every remaining beat of that burst also fails. This holds even if the slave answers those beats normally. A sticky error bit gathers every failed result until software clears it.

The result leaves as a valid-qualified stream with no ready input, so the block applies no back-pressure. A consumer must take `res_ok` in the single cycle where `res_valid` is high. `res_ok` holds its value until the next result. At most one result is produced per cycle.

Top module: `wr_done_mon`

## Requirements
- R1: After synchronous active-high reset, `res_valid`, `res_ok` and `err_sticky` are all 0.
- R2: A phase that closes (`ph_act`=1, `slv_rdy`=1) with `slv_ack`=2'b01 and no abort in any of its cycles gives `res_valid`=1 with `res_ok`=1 in the next cycle.
- R3: While `slv_rdy` is 0 the phase stays open, and no result is produced during any wait-state cycle.
- R4: Closing with `slv_ack`=2'b11 (slave error) gives `res_ok`=0.
- R5: Closing with `slv_ack`=2'b10 (slave retry) gives `res_ok`=0.
- R6: Closing with `slv_ack`=2'b00 gives `res_ok`=0.
- R7: `mst_abort_n`=0 in the closing cycle gives `res_ok`=0, even with `slv_ack`=2'b01.
- R8: `mst_abort_n`=0 in any wait-state cycle gives `res_ok`=0 for that phase, even when abort has been released before the closing cycle.
- R9: After an abort while `burst`=1, every later phase that closes while `burst` stays 1 gives `res_ok`=0, whatever its acknowledge code.
- R10: The burst-abort state is cleared by any cycle with `burst`=0. A following non-burst phase that closes normally gives `res_ok`=1.
- R11: Any `res_ok`=0 result sets `err_sticky` in the same cycle as its `res_valid`. `err_sticky` stays set through later good results. `err_clr`=1 clears it at the next edge, but a failing result in the same cycle takes priority and keeps it set.
- R12: `res_valid` is a single-cycle pulse per closed phase, and `res_ok` keeps its value until the next result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ph_act | input | 1 | A write data phase is in progress this cycle |
| burst | input | 1 | The current transfer is part of a burst |
| slv_rdy | input | 1 | Slave ready strobe; high closes the phase |
| slv_ack | input | 2 | Slave acknowledge code, read only when ready is high |
| mst_abort_n | input | 1 | Master abort, active low |
| err_clr | input | 1 | Clears the sticky error bit |
| res_valid | output | 1 | One-cycle strobe marking a new result |
| res_ok | output | 1 | 1 = normal completion, 0 = any error |
| err_sticky | output | 1 | Set by any failed result until cleared |

## Verification
The monitor keeps two pieces of internal state. One is the wait-state abort latch and the other is the burst-kill flag. Neither can be seen directly, and each shows up only as a wrong `res_ok` one cycle after a later closing cycle. The bench therefore ends every abort scenario with a phase that the slave acknowledges normally. A stuck or lost latch then turns into a visibly wrong flag within that one result. A kill flag that fails to clear appears as a false failure on the first normal phase after the burst drops. A wrong sticky bit shows at once in the same cycle as the result that should have set it, and it stays wrong until the next clear.

// File: rtl/wdm_pkg.sv
package wdm_pkg;
  localparam int ACK_W = 2;
  localparam logic [ACK_W-1:0] ACK_OKAY  = 2'b01;
  localparam logic [ACK_W-1:0] ACK_RETRY = 2'b10;
  localparam logic [ACK_W-1:0] ACK_ERROR = 2'b11;
endpackage

// File: rtl/wdm_phase_track.sv
module wdm_phase_track
  import wdm_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             ph_act,
  input  logic             burst,
  input  logic             slv_rdy,
  input  logic [ACK_W-1:0] slv_ack,
  input  logic             mst_abort_n,
  output logic             close_o,
  output logic             fail_o
);
  logic abort_pend;  // abort seen in a wait state of the open phase
  logic burst_kill;  // abort seen earlier in the current burst
  logic abort_now;

  always_comb begin
    abort_now = ph_act & ~mst_abort_n;
    close_o   = ph_act & slv_rdy;
    fail_o    = abort_pend | abort_now | burst_kill | (slv_ack != ACK_OKAY);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      abort_pend <= 1'b0;
      burst_kill <= 1'b0;
    end else begin
      abort_pend <= (ph_act & ~slv_rdy) ? (abort_pend | ~mst_abort_n) : 1'b0;
      burst_kill <= burst ? (burst_kill | abort_now) : 1'b0;
    end
  end

  // R8: a wait-state abort must reach the closing cycle of the same phase
  p_wait_abort_held_r8: assert property (@(posedge clk) disable iff (rst)
    (ph_act && !slv_rdy && !mst_abort_n) |=> (ph_act && slv_rdy) -> fail_o);

  // R10: leaving the burst drops the kill state
  p_kill_cleared_r10: assert property (@(posedge clk) disable iff (rst)
    (!burst) |=> !burst_kill);
endmodule

// File: rtl/wdm_report.sv
module wdm_report (
  input  logic clk,
  input  logic rst,
  input  logic close_i,
  input  logic fail_i,
  input  logic err_clr,
  output logic res_valid,
  output logic res_ok,
  output logic err_sticky
);
  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid  <= 1'b0;
      res_ok     <= 1'b0;
      err_sticky <= 1'b0;
    end else begin
      res_valid <= close_i;
      if (close_i) res_ok <= ~fail_i;
      err_sticky <= (close_i & fail_i) | (err_sticky & ~err_clr);
    end
  end

  // R11: every failed result is visible in the sticky bit at once
  p_sticky_on_fail_r11: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_ok) |-> err_sticky);

  // R12: without a new closing phase, the flag keeps its value
  p_flag_hold_r12: assert property (@(posedge clk) disable iff (rst)
    !close_i |=> $stable(res_ok));
endmodule

// File: rtl/wr_done_mon.sv
module wr_done_mon
  import wdm_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             ph_act,
  input  logic             burst,
  input  logic             slv_rdy,
  input  logic [ACK_W-1:0] slv_ack,
  input  logic             mst_abort_n,
  input  logic             err_clr,
  output logic             res_valid,
  output logic             res_ok,
  output logic             err_sticky
);
  logic close_w;
  logic fail_w;

  wdm_phase_track u_track (
    .clk(clk), .rst(rst), .ph_act(ph_act), .burst(burst), .slv_rdy(slv_rdy),
    .slv_ack(slv_ack), .mst_abort_n(mst_abort_n),
    .close_o(close_w), .fail_o(fail_w)
  );

  wdm_report u_rep (
    .clk(clk), .rst(rst), .close_i(close_w), .fail_i(fail_w), .err_clr(err_clr),
    .res_valid(res_valid), .res_ok(res_ok), .err_sticky(err_sticky)
  );

  // R3: no result after a wait-state cycle
  p_no_result_in_wait_r3: assert property (@(posedge clk) disable iff (rst)
    !(ph_act && slv_rdy) |=> !res_valid);

  // R4: slave error code fails
  p_slave_err_r4: assert property (@(posedge clk) disable iff (rst)
    (ph_act && slv_rdy && slv_ack == ACK_ERROR) |=> (res_valid && !res_ok));

  // R5: slave retry code fails
  p_slave_retry_r5: assert property (@(posedge clk) disable iff (rst)
    (ph_act && slv_rdy && slv_ack == ACK_RETRY) |=> (res_valid && !res_ok));

  // R7: abort in the closing cycle fails
  p_close_abort_r7: assert property (@(posedge clk) disable iff (rst)
    (ph_act && slv_rdy && !mst_abort_n) |=> (res_valid && !res_ok));

  // R12: the valid strobe never lasts two cycles for one phase
  p_valid_pulse_r12: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !$past(ph_act && slv_rdy)) |-> 1'b0);
endmodule

// File: tb/wr_done_mon_test.sv
module wr_done_mon_test;
  logic       clk = 1'b0;
  logic       rst, ph_act, burst, slv_rdy, mst_abort_n, err_clr;
  logic [1:0] slv_ack;
  logic       res_valid, res_ok, err_sticky;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;  // 250 MHz

  wr_done_mon uut (
    .clk(clk), .rst(rst), .ph_act(ph_act), .burst(burst), .slv_rdy(slv_rdy),
    .slv_ack(slv_ack), .mst_abort_n(mst_abort_n), .err_clr(err_clr),
    .res_valid(res_valid), .res_ok(res_ok), .err_sticky(err_sticky)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle();
    ph_act = 0; slv_rdy = 0; slv_ack = 2'b00; mst_abort_n = 1; err_clr = 0;
  endtask

  // One phase: nw wait states, optional abort in wait states / closing cycle.
  task automatic phase(input int nw, input bit ab_wait, input bit ab_close,
                       input logic [1:0] ack, input bit exp_ok, input string req);
    for (int i = 0; i < nw; i++) begin
      ph_act = 1; slv_rdy = 0; slv_ack = 2'b00; mst_abort_n = !(ab_wait && i == 0);
      @(negedge clk);
      chk(res_valid == 0, "R3", res_valid, 0);
    end
    ph_act = 1; slv_rdy = 1; slv_ack = ack; mst_abort_n = !ab_close;
    @(negedge clk);
    idle();
    chk(res_valid == 1, "R12", res_valid, 1);
    chk(res_ok == exp_ok, req, res_ok, exp_ok);
    @(negedge clk);
    chk(res_valid == 0, "R12", res_valid, 0);
    chk(res_ok == exp_ok, "R12", res_ok, exp_ok);
  endtask

  task automatic t_reset();
    rst = 1; burst = 0; idle();
    repeat (2) @(negedge clk);
    rst = 0;
    chk(res_valid == 0 && res_ok == 0 && err_sticky == 0, "R1",
        {res_valid, res_ok, err_sticky}, 0);
  endtask

  task automatic t_codes();
    phase(0, 0, 0, 2'b01, 1, "R2");
    phase(3, 0, 0, 2'b01, 1, "R3");
    phase(1, 0, 0, 2'b11, 0, "R4");
    phase(0, 0, 0, 2'b10, 0, "R5");
    phase(2, 0, 0, 2'b00, 0, "R6");
  endtask

  task automatic t_aborts();
    phase(0, 0, 1, 2'b01, 0, "R7");
    phase(2, 1, 0, 2'b01, 0, "R8");
    phase(2, 0, 0, 2'b01, 1, "R8");  // latch released after the phase
  endtask

  task automatic t_burst();
    burst = 1;
    phase(0, 0, 0, 2'b01, 1, "R9");
    phase(1, 0, 1, 2'b01, 0, "R9");
    phase(0, 0, 0, 2'b01, 0, "R9");
    phase(2, 0, 0, 2'b01, 0, "R9");
    burst = 0;
    @(negedge clk);
    phase(0, 0, 0, 2'b01, 1, "R10");
  endtask

  task automatic t_sticky();
    err_clr = 1; @(negedge clk); err_clr = 0;
    chk(err_sticky == 0, "R11", err_sticky, 0);
    phase(0, 0, 0, 2'b11, 0, "R11");
    chk(err_sticky == 1, "R11", err_sticky, 1);
    phase(0, 0, 0, 2'b01, 1, "R11");
    chk(err_sticky == 1, "R11", err_sticky, 1);
    err_clr = 1; @(negedge clk); err_clr = 0;
    chk(err_sticky == 0, "R11", err_sticky, 0);
    ph_act = 1; slv_rdy = 1; slv_ack = 2'b10; err_clr = 1;
    @(negedge clk);
    idle();
    chk(err_sticky == 1 && res_ok == 0, "R11", err_sticky, 1);
    @(negedge clk);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_codes();
    t_aborts();
    t_burst();
    t_sticky();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule